// File: doc/BRIEF.md
# Two-Wire Dual Potentiometer Command Slave

This block is the serial front end of a dual digital potentiometer. It watches an open-drain two-wire bus (clock and data lines, sampled into the system clock domain) and frames the commands that a bus master sends. It recognises an identification byte, captures an instruction byte, and then does one of four things: it accepts a data byte, it shifts a read byte out, it turns clock pulses into wiper steps, or it closes a two-byte transfer. Each completed command is handed to a register bank as a one-cycle strobe. The strobe carries a command kind, a register index, a pot index and, for writes, the data.

The register bank returns read data on `rd_data_i` for whichever register `sel_reg_o`, `sel_pot_o` and `sel_src_o` point at. The bank also raises `nv_busy_i` while a nonvolatile store is in progress. During that time the slave refuses to acknowledge its own address, so a master can poll until the store has finished. The data line is driven through `sda_drv_n_o`: low pulls the bus low, high releases it.

Top module: `dpot_cmd_slave`

## Requirements
- R1: A START (data falling while clock is high) begins identification-byte capture from any state, including a repeated START in the middle of a frame. The aborted frame produces no strobe, and the data line is released on the cycle after the START.
- R2: The identification byte is taken MSB first. Its upper nibble must be 0101 and its lower nibble must equal `dev_addr_i`. Otherwise the slave gives no acknowledge and ignores every bit until the next START.
- R3: The slave pulls the data line low during the ninth clock after three bytes: a matching identification byte, the instruction byte, and the data byte of a write.
- R4: While `nv_busy_i` is high at the end of the identification byte, a matching address receives no acknowledge and the frame is ignored.
- R5: The instruction byte is laid out MSB first as opcode[3:0], register index[1:0], a don't-care bit, pot index. The indices appear on `sel_reg_o` and `sel_pot_o` from the end of that byte onward.
- R6: Opcode 1010 (wiper write, kind 0) and opcode 1100 (data register write, kind 1) take one data byte. They strobe `cmd_valid_o` for one cycle on the STOP that follows, with `cmd_kind_o` and `cmd_data_o` set to that kind and that byte.
- R7: Four opcodes are two-byte transfers that strobe on the STOP after the instruction byte: 1101 register to wiper (kind 2), 1110 wiper to register (kind 3), 0001 all registers to wipers (kind 4), and 1000 all wipers to registers (kind 5).
- R8: Opcodes 1001 (read wiper, `sel_src_o`=1) and 1011 (read data register, `sel_src_o`=0) capture `rd_data_i` at the end of the instruction acknowledge. The captured byte is shifted out MSB first, each bit set up after a clock fall. The line is released after the eighth bit, and no strobe is produced.
- R9: After opcode 0010 is acknowledged, each complete clock pulse (a rise followed by a fall) gives one `step_o` pulse at the fall. `step_up_o` is 1 if data was high at the rise and 0 if it was low. A clock rise that is ended by a STOP gives no step.
- R10: Any other opcode is acknowledged but produces no strobe.
- R11: A STOP before a command is complete (a write without its data byte, or a STOP during any byte) produces no strobe.
- R12: Out of reset the data line is released. `sda_drv_n_o` changes only while the clock is low, except for the release that follows a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| dev_addr_i | input | 4 | Slave address strap |
| nv_busy_i | input | 1 | Nonvolatile store in progress |
| rd_data_i | input | 8 | Read data from the register bank for the current selection |
| sda_drv_n_o | output | 1 | Data line drive, 0 pulls low |
| sel_reg_o | output | 2 | Data register index from the instruction byte |
| sel_pot_o | output | 1 | Pot index from the instruction byte |
| sel_src_o | output | 1 | 1 when a read targets the wiper register |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_kind_o | output | 3 | Command kind (0..5) |
| cmd_data_o | output | 8 | Write payload |
| step_o | output | 1 | One-cycle wiper step strobe |
| step_up_o | output | 1 | Step direction, 1 toward the high end |

## Verification
The embedded assertions watch four rules on every cycle: the data line is released after a START, the drive changes only while the clock is low, command strobes appear only right after a STOP, and step pulses happen only on a clock fall. The busy rule is checked as well: a matching address seen while busy sends the slave back to idle. The scenarios cover the parts that only a full frame can show. These are the values and kinds carried by each strobe, the bit order of read data, the order and direction of wiper steps, and the absence of any strobe after an address mismatch, an unknown opcode, a truncated write or a repeated START.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        K_WR_WIPER      = 3'd0,
        K_WR_REG        = 3'd1,
        K_REG2WIPER     = 3'd2,
        K_WIPER2REG     = 3'd3,
        K_ALL_REG2WIPER = 3'd4,
        K_ALL_WIPER2REG = 3'd5
    } kind_e;

    typedef enum logic [2:0] {
        C_NONE,
        C_READ,
        C_WRITE,
        C_XFER,
        C_STEP
    } cls_e;

    typedef struct packed {
        cls_e  cls;
        kind_e kind;
        logic  from_wiper;
    } ins_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID,
        ST_ID_ACK,
        ST_INS,
        ST_INS_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_STEP,
        ST_HOLD
    } st_e;

    function automatic ins_t decode_op(input logic [3:0] op);
        ins_t r;
        r.cls        = C_NONE;
        r.kind       = K_WR_WIPER;
        r.from_wiper = 1'b0;
        case (op)
            4'b1001: begin r.cls = C_READ;  r.from_wiper = 1'b1; end
            4'b1011: begin r.cls = C_READ;  r.from_wiper = 1'b0; end
            4'b1010: begin r.cls = C_WRITE; r.kind = K_WR_WIPER; end
            4'b1100: begin r.cls = C_WRITE; r.kind = K_WR_REG; end
            4'b1101: begin r.cls = C_XFER;  r.kind = K_REG2WIPER; end
            4'b1110: begin r.cls = C_XFER;  r.kind = K_WIPER2REG; end
            4'b0001: begin r.cls = C_XFER;  r.kind = K_ALL_REG2WIPER; end
            4'b1000: begin r.cls = C_XFER;  r.kind = K_ALL_WIPER2REG; end
            4'b0010: begin r.cls = C_STEP; end
            default: r.cls = C_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dpot_line_mon.sv
module dpot_line_mon
    import dpot_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o,
    output logic    scl_q_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev_o.start = scl_q & scl_i & sda_q & ~sda_i;
        ev_o.stop  = scl_q & scl_i & ~sda_q & sda_i;
        ev_o.rise  = ~scl_q & scl_i;
        ev_o.fall  = scl_q & ~scl_i;
        ev_o.sda   = sda_i;
    end

    assign scl_q_o = scl_q;

endmodule

// File: rtl/dpot_ins_decode.sv
module dpot_ins_decode
    import dpot_pkg::*;
(
    input  logic [3:0] op_i,
    output ins_t       ins_o
);

    assign ins_o = decode_op(op_i);

endmodule

// File: rtl/dpot_frame_ctrl.sv
module dpot_frame_ctrl
    import dpot_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [BYTE_W-ADDR_W-1:0] DEV_TYPE = 4'b0101
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev_i,
    input  logic              scl_q_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    input  logic              nv_busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    input  ins_t              dec_i,
    output logic [3:0]        op_nib_o,
    output logic              sda_drv_n_o,
    output logic [1:0]        sel_reg_o,
    output logic              sel_pot_o,
    output logic              sel_src_o,
    output logic              cmd_valid_o,
    output kind_e             cmd_kind_o,
    output logic [BYTE_W-1:0] cmd_data_o,
    output logic              step_o,
    output logic              step_up_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    st_e               st;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] nxt;
    logic [BYTE_W-1:0] data_q;
    logic              drv_n;
    logic              ack_on;
    logic              frame_ok;
    logic              step_arm;
    logic              step_dir;
    logic              id_hit;
    ins_t              ins_q;
    logic [1:0]        reg_q;
    logic              pot_q;

    assign nxt      = {shreg[BYTE_W-2:0], ev_i.sda};
    assign op_nib_o = nxt[BYTE_W-1 -: 4];
    assign id_hit   = (nxt[BYTE_W-1:ADDR_W] == DEV_TYPE) &&
                      (nxt[ADDR_W-1:0] == dev_addr_i) && !nv_busy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            bit_cnt     <= '0;
            shreg       <= '0;
            data_q      <= '0;
            drv_n       <= 1'b1;
            ack_on      <= 1'b0;
            frame_ok    <= 1'b0;
            step_arm    <= 1'b0;
            step_dir    <= 1'b0;
            ins_q       <= '0;
            reg_q       <= '0;
            pot_q       <= 1'b0;
            cmd_valid_o <= 1'b0;
            step_o      <= 1'b0;
            step_up_o   <= 1'b0;
        end else begin
            cmd_valid_o <= 1'b0;
            step_o      <= 1'b0;
            if (ev_i.start) begin
                st       <= ST_ID;
                bit_cnt  <= '0;
                drv_n    <= 1'b1;
                ack_on   <= 1'b0;
                frame_ok <= 1'b0;
                step_arm <= 1'b0;
            end else if (ev_i.stop) begin
                st       <= ST_IDLE;
                drv_n    <= 1'b1;
                ack_on   <= 1'b0;
                step_arm <= 1'b0;
                frame_ok <= 1'b0;
                if (frame_ok) cmd_valid_o <= 1'b1;
            end else begin
                case (st)
                    ST_ID, ST_INS, ST_WDAT: begin
                        if (ev_i.rise) begin
                            shreg   <= nxt;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST) begin
                                case (st)
                                    ST_ID:   st <= id_hit ? ST_ID_ACK : ST_IDLE;
                                    ST_INS: begin
                                        st    <= ST_INS_ACK;
                                        ins_q <= dec_i;
                                        reg_q <= nxt[3:2];
                                        pot_q <= nxt[0];
                                    end
                                    default: begin
                                        st     <= ST_WDAT_ACK;
                                        data_q <= nxt;
                                    end
                                endcase
                            end
                        end
                    end
                    ST_ID_ACK, ST_INS_ACK, ST_WDAT_ACK: begin
                        if (ev_i.fall) begin
                            if (!ack_on) begin
                                drv_n  <= 1'b0;
                                ack_on <= 1'b1;
                            end else begin
                                drv_n   <= 1'b1;
                                ack_on  <= 1'b0;
                                bit_cnt <= '0;
                                case (st)
                                    ST_ID_ACK: st <= ST_INS;
                                    ST_INS_ACK: begin
                                        case (ins_q.cls)
                                            C_READ: begin
                                                shreg <= rd_data_i;
                                                drv_n <= rd_data_i[BYTE_W-1];
                                                st    <= ST_RDAT;
                                            end
                                            C_WRITE: st <= ST_WDAT;
                                            C_STEP:  st <= ST_STEP;
                                            C_XFER: begin
                                                frame_ok <= 1'b1;
                                                st       <= ST_HOLD;
                                            end
                                            default: st <= ST_HOLD;
                                        endcase
                                    end
                                    default: begin
                                        frame_ok <= 1'b1;
                                        st       <= ST_HOLD;
                                    end
                                endcase
                            end
                        end
                    end
                    ST_RDAT: begin
                        if (ev_i.rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (ev_i.fall) begin
                            if (bit_cnt == '0) begin
                                drv_n <= 1'b1;
                                st    <= ST_HOLD;
                            end else begin
                                drv_n <= shreg[LAST - bit_cnt];
                            end
                        end
                    end
                    ST_STEP: begin
                        if (ev_i.rise) begin
                            step_dir <= ev_i.sda;
                            step_arm <= 1'b1;
                        end else if (ev_i.fall && step_arm) begin
                            step_o    <= 1'b1;
                            step_up_o <= step_dir;
                            step_arm  <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_drv_n_o = drv_n;
    assign sel_reg_o   = reg_q;
    assign sel_pot_o   = pot_q;
    assign sel_src_o   = ins_q.from_wiper;
    assign cmd_kind_o  = ins_q.kind;
    assign cmd_data_o  = data_q;

    AST_RELEASE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        ev_i.start |=> sda_drv_n_o); // R1

    AST_IDLE_OFF_BUS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> sda_drv_n_o); // R2

    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ID && ev_i.rise && !ev_i.start && bit_cnt == LAST && nv_busy_i)
        |=> (st == ST_IDLE)); // R4

    AST_CMD_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> $past(ev_i.stop)); // R6

    AST_STEP_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        step_o |-> !scl_q_i); // R9

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_drv_n_o) && !$past(ev_i.start) && !$past(ev_i.stop))
        |-> !scl_q_i); // R12

endmodule

// File: rtl/dpot_cmd_slave.sv
module dpot_cmd_slave
    import dpot_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [BYTE_W-ADDR_W-1:0] DEV_TYPE = 4'b0101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    input  logic              nv_busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_drv_n_o,
    output logic [1:0]        sel_reg_o,
    output logic              sel_pot_o,
    output logic              sel_src_o,
    output logic              cmd_valid_o,
    output logic [2:0]        cmd_kind_o,
    output logic [BYTE_W-1:0] cmd_data_o,
    output logic              step_o,
    output logic              step_up_o
);

    bus_ev_t    ev;
    logic       scl_q;
    logic [3:0] op_nib;
    ins_t       dec;
    kind_e      kind;

    dpot_line_mon u_line (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .ev_o    (ev),
        .scl_q_o (scl_q)
    );

    dpot_ins_decode u_dec (
        .op_i  (op_nib),
        .ins_o (dec)
    );

    dpot_frame_ctrl #(
        .ADDR_W   (ADDR_W),
        .DEV_TYPE (DEV_TYPE)
    ) u_frame (
        .clk         (clk),
        .rst         (rst),
        .ev_i        (ev),
        .scl_q_i     (scl_q),
        .dev_addr_i  (dev_addr_i),
        .nv_busy_i   (nv_busy_i),
        .rd_data_i   (rd_data_i),
        .dec_i       (dec),
        .op_nib_o    (op_nib),
        .sda_drv_n_o (sda_drv_n_o),
        .sel_reg_o   (sel_reg_o),
        .sel_pot_o   (sel_pot_o),
        .sel_src_o   (sel_src_o),
        .cmd_valid_o (cmd_valid_o),
        .cmd_kind_o  (kind),
        .cmd_data_o  (cmd_data_o),
        .step_o      (step_o),
        .step_up_o   (step_up_o)
    );

    assign cmd_kind_o = kind;

endmodule

// File: tb/dpot_cmd_slave_tb.sv
module dpot_cmd_slave_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       nv_busy = 1'b0;
    logic [3:0] my_addr = 4'hA;
    logic [7:0] rd_data;
    logic       sda_line;
    logic       drv_n;
    logic [1:0] sel_reg;
    logic       sel_pot, sel_src;
    logic       cmd_valid, step, step_up;
    logic [2:0] cmd_kind;
    logic [7:0] cmd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        bit       is_step;
        bit       up;
        bit [2:0] kind;
        bit [1:0] rsel;
        bit       pot;
        bit [7:0] data;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & drv_n;
    assign rd_data  = sel_src ? {4'h9, 3'b000, sel_pot} : {4'hC, sel_reg, 1'b0, sel_pot};

    dpot_cmd_slave dut_i (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .dev_addr_i(my_addr), .nv_busy_i(nv_busy), .rd_data_i(rd_data),
        .sda_drv_n_o(drv_n), .sel_reg_o(sel_reg), .sel_pot_o(sel_pot),
        .sel_src_o(sel_src), .cmd_valid_o(cmd_valid), .cmd_kind_o(cmd_kind),
        .cmd_data_o(cmd_data), .step_o(step), .step_up_o(step_up)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(2); scl = 1'b1; w(2); sda_m = 1'b0; w(2); scl = 1'b0; w(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(2); scl = 1'b1; w(2); sda_m = 1'b1; w(4);
    endtask

    task automatic bit_out(input bit b);
        sda_m = b; w(2); scl = 1'b1; w(4); scl = 1'b0; w(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_m = 1'b1; w(2); scl = 1'b1; w(2);
        acked = !sda_line;
        w(2); scl = 1'b0; w(2);
    endtask

    task automatic read_byte(output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; w(2); scl = 1'b1; w(2);
            d[i] = sda_line;
            w(2); scl = 1'b0; w(2);
        end
    endtask

    task automatic push_cmd(input bit [2:0] k, input bit [1:0] r, input bit p, input bit [7:0] d);
        exp_t e;
        e.is_step = 0; e.up = 0; e.kind = k; e.rsel = r; e.pot = p; e.data = d;
        exp_q.push_back(e);
    endtask

    task automatic push_step(input bit up, input bit p);
        exp_t e;
        e.is_step = 1; e.up = up; e.kind = 0; e.rsel = 0; e.pot = p; e.data = 0;
        exp_q.push_back(e);
    endtask

    task automatic hdr(input logic [3:0] op, input logic [1:0] r, input bit p, input string req);
        bit a;
        bus_start();
        send_byte({4'b0101, my_addr}, a);
        chk(a, "R3", "id ack", a, 1);
        send_byte({op, r, 1'b0, p}, a);
        chk(a, req, "instruction ack", a, 1);
    endtask

    task automatic wr_cmd(input logic [3:0] op, input bit [2:0] k, input logic [1:0] r,
                          input bit p, input logic [7:0] d, input string req);
        bit a;
        hdr(op, r, p, req);
        send_byte(d, a);
        chk(a, "R3", "data ack", a, 1);
        push_cmd(k, r, p, d);
        bus_stop();
    endtask

    task automatic xfer(input logic [3:0] op, input bit [2:0] k, input logic [1:0] r,
                        input bit p);
        hdr(op, r, p, "R7");
        push_cmd(k, r, p, 8'h00);
        bus_stop();
    endtask

    task automatic drained(input string req);
        w(4);
        chk(exp_q.size() == 0, req, "pending expected events", exp_q.size(), 0);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && (cmd_valid || step)) begin
            if (exp_q.size() == 0) begin
                chk(0, "R10", "unexpected strobe kind", {cmd_valid, step, cmd_kind}, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.is_step) begin
                    chk(step && !cmd_valid, "R9", "step strobe", step, 1);
                    chk(step_up == e.up, "R9", "step direction", step_up, e.up);
                    chk(sel_pot == e.pot, "R9", "step pot", sel_pot, e.pot);
                end else begin
                    chk(cmd_valid && !step, "R6", "command strobe", cmd_valid, 1);
                    chk(cmd_kind == e.kind, "R7", "kind", cmd_kind, e.kind);
                    if (e.kind != 3'd0)
                        chk(sel_reg == e.rsel, "R5", "register index", sel_reg, e.rsel);
                    if (e.kind < 3'd4)
                        chk(sel_pot == e.pot, "R5", "pot index", sel_pot, e.pot);
                    if (e.kind <= 3'd1)
                        chk(cmd_data == e.data, "R6", "payload", cmd_data, e.data);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] d;
        w(4);
        rst = 1'b0;
        w(2);
        // R12 reset state
        chk(drv_n == 1'b1, "R12", "released after reset", drv_n, 1);
        chk(!cmd_valid && !step, "R12", "no strobe after reset", {cmd_valid, step}, 0);

        // R6 writes
        wr_cmd(4'b1010, 3'd0, 2'd0, 1'b1, 8'hA5, "R6");
        drained("R6");
        wr_cmd(4'b1100, 3'd1, 2'd2, 1'b0, 8'h3C, "R6");
        drained("R6");
        chk(sel_reg == 2'd2, "R5", "register index held", sel_reg, 2);

        // R7 transfers
        xfer(4'b1101, 3'd2, 2'd1, 1'b1);
        xfer(4'b1110, 3'd3, 2'd3, 1'b0);
        xfer(4'b0001, 3'd4, 2'd2, 1'b0);
        xfer(4'b1000, 3'd5, 2'd1, 1'b0);
        drained("R7");

        // R8 reads
        hdr(4'b1011, 2'd3, 1'b1, "R8");
        read_byte(d);
        chk(d == 8'hCD, "R8", "data register read", d, 8'hCD);
        bit_out(1'b1);
        chk(drv_n == 1'b1, "R8", "released after read", drv_n, 1);
        bus_stop();
        hdr(4'b1001, 2'd0, 1'b0, "R8");
        read_byte(d);
        chk(d == 8'h90, "R8", "wiper read", d, 8'h90);
        bit_out(1'b1);
        bus_stop();
        drained("R8");

        // R2 address mismatch and wrong type
        bus_start();
        send_byte({4'b0101, ~my_addr}, a);
        chk(!a, "R2", "mismatched address acked", a, 0);
        send_byte(8'hA2, a);
        chk(!a, "R2", "ignored byte acked", a, 0);
        bus_stop();
        bus_start();
        send_byte({4'b0110, my_addr}, a);
        chk(!a, "R2", "wrong type acked", a, 0);
        bus_stop();
        drained("R2");

        // R4 busy polling
        nv_busy = 1'b1;
        bus_start();
        send_byte({4'b0101, my_addr}, a);
        chk(!a, "R4", "acked while busy", a, 0);
        bus_stop();
        nv_busy = 1'b0;
        xfer(4'b1110, 3'd3, 2'd0, 1'b1);
        drained("R4");

        // R10 unknown opcode
        hdr(4'b0000, 2'd1, 1'b1, "R10");
        bus_stop();
        drained("R10");

        // R11 truncated write
        hdr(4'b1010, 2'd0, 1'b0, "R11");
        bus_stop();
        drained("R11");

        // R9 steps
        hdr(4'b0010, 2'd0, 1'b1, "R9");
        push_step(1, 1); bit_out(1'b1);
        push_step(1, 1); bit_out(1'b1);
        push_step(1, 1); bit_out(1'b1);
        push_step(0, 1); bit_out(1'b0);
        push_step(0, 1); bit_out(1'b0);
        bus_stop();
        drained("R9");

        // R1 repeated start inside data byte
        hdr(4'b1010, 2'd0, 1'b0, "R1");
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
        wr_cmd(4'b1100, 3'd1, 2'd1, 1'b1, 8'h5A, "R1");
        drained("R1");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule